// File: doc/BRIEF.md
# Pulse tone voice with envelope, sweep and duration counter

This block produces one square-wave voice for a sound unit. A CPU-rate tick drives an 11-bit down-counting timer whose output is halved and then steps an 8-position duty pattern. The pattern gates a 4-bit volume that comes either from a fixed register value or from a decaying envelope. A sweep unit can slide the period up or down on every half-frame pulse, and a duration counter, loaded from a 32-entry table, silences the voice when it runs out.

Software reaches the block through four byte-wide write registers selected by a 2-bit address. The frame sequencer outside the block supplies quarter-frame and half-frame pulses, and the shared status register reads the duration counter's nonzero flag. Whether the sweep subtracts with ones-complement or twos-complement arithmetic is fixed by a parameter, so two instances can differ by one count when sweeping downward. Mixing of voices is left to the surrounding design.

Top module: `pulse_voice`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `level_out` is 0 and `len_active` is 0.
- R2: The timer reloads with the 11-bit period P (register 2 is P[7:0], register 3 bits 2:0 are P[10:8]) and so fires once every P+1 ticks; every second firing advances the step counter by one. The step is a 3-bit position and wraps from 7 to 0.
- R3: For step s the wave bit is bit (7-s) of the duty pattern picked by register 0 bits 7:6: 0 -> 01000000, 1 -> 01100000, 2 -> 01111000, 3 -> 10011111 (written MSB first, so step 0 is the leftmost bit). A register-3 write returns the step to 0; a register-0 write does not move the step.
- R4: A register-3 write arms the envelope; the next quarter-frame pulse sets the envelope level to 15 and reloads its divider with n (register 0 bits 3:0). Any other quarter-frame pulse decrements the divider, or, when it is 0, reloads it with n and either decrements a nonzero level or, with register 0 bit 5 set, wraps level 0 to 15.
- R5: With register 0 bit 4 set the voice volume is n; with it clear the volume is the envelope level.
- R6: The sweep target is P + (P >> s), s = register 1 bits 2:0, when register 1 bit 3 is clear; when it is set the target is P - (P >> s) - 1 in ones-complement style or P - (P >> s) in twos-complement style, clamped at 0.
- R7: The voice is muted (output 0, period left unchanged by the sweep) while P < 8 or, with negate clear, the addition carries beyond 11 bits.
- R8: On a half-frame pulse the sweep divider fires if it is 0 and is reloaded with register 1 bits 6:4 when it fires or when register 1 was written since the last half-frame pulse, else it decrements. On firing, with register 1 bit 7 set, s nonzero and no mute, P takes the target.
- R9: A register-3 write while `chan_en` is 1 loads the duration counter from the table indexed by data bits 7:3 (odd index k gives 2*(k>>1), or 254 for k=1; even index gives 10,20,40,80,160,60,14,26,12,24,48,96,192,72,16,32 for k/2 = 0..15); while `chan_en` is 0 such a write leaves it at 0.
- R10: On a half-frame pulse the duration counter decrements when nonzero and register 0 bit 5 is clear; `chan_en` low forces it to 0 in the next cycle and holds it there.
- R11: `level_out` equals the volume when the wave bit is 1, the duration counter is nonzero and the voice is not muted, and is 0 otherwise.
- R12: `len_active` is 1 exactly when the duration counter is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick | input | 1 | Timer advance strobe at CPU rate |
| qtr_pulse | input | 1 | Quarter-frame strobe (envelope) |
| half_pulse | input | 1 | Half-frame strobe (sweep, duration) |
| chan_en | input | 1 | Voice enable from the shared control register |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select 0..3 |
| wr_data | input | 8 | Register write data |
| level_out | output | 4 | Voice output level |
| len_active | output | 1 | Duration counter nonzero |

## Verification
A bench-side model built from the requirements is compared with the outputs every cycle while the bench drives a fixed-seed random mix of register writes, tick gaps, frame pulses and enable changes. Directed runs then separate the cases random traffic rarely hits: a short table entry that must expire after exactly two half-frame pulses, the halt bit holding the count, writes while disabled, a period below 8 that must stay silent, and upward and downward sweeps that distinguish the negation styles. An envelope run with n = 0 shows the fastest decay and the loop wrap.

// File: rtl/pulse_voice_pkg.sv
package pulse_voice_pkg;

   typedef struct packed {
      logic [1:0] duty;
      logic       loop_halt;
      logic       const_vol;
      logic [3:0] vol;
   } voice_ctl_t;

   typedef struct packed {
      logic       enable;
      logic [2:0] rate;
      logic       negate;
      logic [2:0] shift;
   } sweep_cfg_t;

   function automatic logic duty_bit(input logic [1:0] duty, input logic [2:0] step);
      logic [7:0] pat;
      case (duty)
         2'd0:    pat = 8'b0100_0000;
         2'd1:    pat = 8'b0110_0000;
         2'd2:    pat = 8'b0111_1000;
         default: pat = 8'b1001_1111;
      endcase
      return pat[3'd7 - step];
   endfunction

   function automatic logic [7:0] dur_lookup(input logic [4:0] idx);
      logic [7:0] v;
      if (idx[0]) begin
         v = (idx[4:1] == 4'd0) ? 8'd254 : {3'b000, idx[4:1], 1'b0};
      end else begin
         case (idx[4:1])
            4'd0:  v = 8'd10;
            4'd1:  v = 8'd20;
            4'd2:  v = 8'd40;
            4'd3:  v = 8'd80;
            4'd4:  v = 8'd160;
            4'd5:  v = 8'd60;
            4'd6:  v = 8'd14;
            4'd7:  v = 8'd26;
            4'd8:  v = 8'd12;
            4'd9:  v = 8'd24;
            4'd10: v = 8'd48;
            4'd11: v = 8'd96;
            4'd12: v = 8'd192;
            4'd13: v = 8'd72;
            4'd14: v = 8'd16;
            default: v = 8'd32;
         endcase
      end
      return v;
   endfunction

endpackage

// File: rtl/pulse_voice_tone.sv
module pulse_voice_tone #(
   parameter int PERIOD_W = 11,
   parameter int STEP_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                restart,
   input  logic [PERIOD_W-1:0] period,
   input  logic [1:0]          duty,
   output logic [STEP_W-1:0]   step,
   output logic                wave
);
   import pulse_voice_pkg::*;

   logic [PERIOD_W-1:0] cnt_q;
   logic                half_q;
   logic [STEP_W-1:0]   step_q;

   if (STEP_W != 3) begin : g_bad_step
      $error("pulse_voice_tone: duty patterns have exactly 8 steps");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         half_q <= 1'b0;
         step_q <= '0;
      end else begin
         if (tick) begin
            if (cnt_q == '0) begin
               cnt_q  <= period;
               half_q <= ~half_q;
               if (half_q) step_q <= step_q + 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         if (restart) step_q <= '0;
      end
   end

   assign step = step_q;
   assign wave = duty_bit(duty, step_q);

endmodule

// File: rtl/pulse_voice_env.sv
module pulse_voice_env #(
   parameter int LEVEL_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               qtr,
   input  logic               arm,
   input  logic               loop_en,
   input  logic               const_vol,
   input  logic [LEVEL_W-1:0] n_val,
   output logic [LEVEL_W-1:0] volume
);
   localparam logic [LEVEL_W-1:0] TOP = '1;

   logic               armed_q;
   logic [LEVEL_W-1:0] div_q;
   logic [LEVEL_W-1:0] lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         div_q   <= '0;
         lvl_q   <= '0;
      end else begin
         if (qtr) begin
            if (armed_q) begin
               lvl_q <= TOP;
               div_q <= n_val;
            end else if (div_q == '0) begin
               div_q <= n_val;
               if (lvl_q != '0)  lvl_q <= lvl_q - 1'b1;
               else if (loop_en) lvl_q <= TOP;
            end else begin
               div_q <= div_q - 1'b1;
            end
         end
         if (arm)      armed_q <= 1'b1;
         else if (qtr) armed_q <= 1'b0;
      end
   end

   assign volume = const_vol ? n_val : lvl_q;

endmodule

// File: rtl/pulse_voice_sweep.sv
module pulse_voice_sweep #(
   parameter int PERIOD_W   = 11,
   parameter int MUTE_BELOW = 8,
   parameter bit NEG_TWOS   = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          half,
   input  logic                          cfg_wr,
   input  pulse_voice_pkg::sweep_cfg_t   cfg,
   input  logic [PERIOD_W-1:0]           period,
   output logic                          mute,
   output logic                          update,
   output logic [PERIOD_W-1:0]           target
);
   logic [PERIOD_W-1:0] shifted;
   logic [PERIOD_W:0]   sum;
   logic [PERIOD_W:0]   dec;
   logic [PERIOD_W-1:0] lowered;
   logic [2:0]          div_q;
   logic                reload_q;
   logic                fire;

   assign shifted = period >> cfg.shift;
   assign sum     = {1'b0, period} + {1'b0, shifted};

   if (NEG_TWOS) begin : g_twos
      assign dec = {1'b0, shifted};
   end else begin : g_ones
      assign dec = {1'b0, shifted} + 1'b1;
   end

   always_comb begin
      if ({1'b0, period} >= dec) lowered = period - dec[PERIOD_W-1:0];
      else                       lowered = '0;
   end

   assign target = cfg.negate ? lowered : sum[PERIOD_W-1:0];
   assign mute   = (period < PERIOD_W'(MUTE_BELOW)) || (!cfg.negate && sum[PERIOD_W]);
   assign fire   = half && (div_q == 3'd0);
   assign update = fire && cfg.enable && (cfg.shift != 3'd0) && !mute;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q    <= 3'd0;
         reload_q <= 1'b0;
      end else begin
         if (half) begin
            if (fire || reload_q) div_q <= cfg.rate;
            else                  div_q <= div_q - 1'b1;
         end
         if (cfg_wr)    reload_q <= 1'b1;
         else if (half) reload_q <= 1'b0;
      end
   end

endmodule

// File: rtl/pulse_voice_dur.sv
module pulse_voice_dur #(
   parameter int IDX_W = 5,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             load,
   input  logic [IDX_W-1:0] idx,
   input  logic             half,
   input  logic             halt,
   output logic             active
);
   import pulse_voice_pkg::*;

   logic [CNT_W-1:0] cnt_q;

   if (IDX_W != 5 || CNT_W != 8) begin : g_bad_dur
      $error("pulse_voice_dur: table is 32 entries of 8 bits");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!enable) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= dur_lookup(idx);
      end else if (half && !halt && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign active = (cnt_q != '0);

endmodule

// File: rtl/pulse_voice.sv
module pulse_voice #(
   parameter int PERIOD_W   = 11,
   parameter int LEVEL_W    = 4,
   parameter int MUTE_BELOW = 8,
   parameter bit NEG_TWOS   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_tick,
   input  logic               qtr_pulse,
   input  logic               half_pulse,
   input  logic               chan_en,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [7:0]         wr_data,
   output logic [LEVEL_W-1:0] level_out,
   output logic               len_active
);
   import pulse_voice_pkg::*;

   localparam int HI_W = PERIOD_W - 8;

   if (PERIOD_W < 9 || PERIOD_W > 11) begin : g_bad_period
      $error("pulse_voice: PERIOD_W must lie in 9..11");
   end
   if (LEVEL_W != 4) begin : g_bad_level
      $error("pulse_voice: control register holds a 4-bit level");
   end

   voice_ctl_t          ctl_q;
   sweep_cfg_t          swp_q;
   logic [PERIOD_W-1:0] period_q;
   logic                wr_ctl, wr_swp, wr_lo, wr_hi;
   logic [2:0]          seq_step;
   logic                wave;
   logic [LEVEL_W-1:0]  volume;
   logic                mute, sw_update;
   logic [PERIOD_W-1:0] sw_target;
   logic                dur_active;

   assign wr_ctl = wr_en && (wr_addr == 2'd0);
   assign wr_swp = wr_en && (wr_addr == 2'd1);
   assign wr_lo  = wr_en && (wr_addr == 2'd2);
   assign wr_hi  = wr_en && (wr_addr == 2'd3);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q    <= '0;
         swp_q    <= '0;
         period_q <= '0;
      end else begin
         if (wr_ctl) ctl_q <= voice_ctl_t'(wr_data);
         if (wr_swp) swp_q <= sweep_cfg_t'(wr_data);
         if (wr_lo || wr_hi) begin
            if (wr_lo) period_q[7:0]          <= wr_data;
            if (wr_hi) period_q[PERIOD_W-1:8] <= wr_data[HI_W-1:0];
         end else if (sw_update) begin
            period_q <= sw_target;
         end
      end
   end

   pulse_voice_tone #(.PERIOD_W(PERIOD_W), .STEP_W(3)) u_tone (
      .clk(clk), .rst_n(rst_n), .tick(cpu_tick), .restart(wr_hi),
      .period(period_q), .duty(ctl_q.duty), .step(seq_step), .wave(wave)
   );

   pulse_voice_env #(.LEVEL_W(LEVEL_W)) u_env (
      .clk(clk), .rst_n(rst_n), .qtr(qtr_pulse), .arm(wr_hi),
      .loop_en(ctl_q.loop_halt), .const_vol(ctl_q.const_vol),
      .n_val(ctl_q.vol), .volume(volume)
   );

   pulse_voice_sweep #(.PERIOD_W(PERIOD_W), .MUTE_BELOW(MUTE_BELOW), .NEG_TWOS(NEG_TWOS)) u_sweep (
      .clk(clk), .rst_n(rst_n), .half(half_pulse), .cfg_wr(wr_swp), .cfg(swp_q),
      .period(period_q), .mute(mute), .update(sw_update), .target(sw_target)
   );

   pulse_voice_dur #(.IDX_W(5), .CNT_W(8)) u_dur (
      .clk(clk), .rst_n(rst_n), .enable(chan_en), .load(wr_hi),
      .idx(wr_data[7:3]), .half(half_pulse), .halt(ctl_q.loop_halt),
      .active(dur_active)
   );

   assign level_out  = (wave && dur_active && !mute) ? volume : '0;
   assign len_active = dur_active;

endmodule

// File: rtl/pulse_voice_chk.sv
module pulse_voice_chk #(
   parameter int PERIOD_W   = 11,
   parameter int LEVEL_W    = 4,
   parameter int MUTE_BELOW = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cpu_tick,
   input logic                half_pulse,
   input logic                chan_en,
   input logic                wr_en,
   input logic [1:0]          wr_addr,
   input logic [LEVEL_W-1:0]  level_out,
   input logic                len_active,
   input logic [PERIOD_W-1:0] period_q,
   input logic [2:0]          seq_step
);
   assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> !len_active);

   assert_gated_by_length_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (level_out != '0) |-> len_active);

   assert_low_period_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (level_out != '0) |-> (period_q >= PERIOD_W'(MUTE_BELOW)));

   assert_load_only_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(len_active) |-> $past(wr_en && wr_addr == 2'd3 && chan_en));

   assert_step_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(seq_step) |-> $past(cpu_tick || (wr_en && wr_addr == 2'd3)));

   assert_period_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(period_q) |-> $past(wr_en || half_pulse));
endmodule

bind pulse_voice pulse_voice_chk #(.PERIOD_W(PERIOD_W), .LEVEL_W(LEVEL_W), .MUTE_BELOW(MUTE_BELOW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .half_pulse(half_pulse),
   .chan_en(chan_en), .wr_en(wr_en), .wr_addr(wr_addr), .level_out(level_out),
   .len_active(len_active), .period_q(period_q), .seq_step(seq_step)
);

// File: tb/pulse_voice_bench.sv
module pulse_voice_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_tick = 1'b0, qtr_pulse = 1'b0, half_pulse = 1'b0, chan_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [3:0] level_out;
   logic       len_active;
   int         checks = 0, failures = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   pulse_voice u_pulse_voice (
      .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .qtr_pulse(qtr_pulse),
      .half_pulse(half_pulse), .chan_en(chan_en), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .level_out(level_out), .len_active(len_active)
   );

   // ---------------- bench model, written from the requirements ----------------
   logic [7:0]  m_r0, m_r1;
   logic [10:0] m_per, m_tcnt;
   logic        m_tgl, m_arm, m_rl;
   logic [2:0]  m_step, m_sdiv;
   logic [3:0]  m_ediv, m_elvl;
   logic [7:0]  m_len;

   function automatic logic [7:0] tbl(input logic [4:0] k);
      logic [7:0] evens [16] = '{10,20,40,80,160,60,14,26,12,24,48,96,192,72,16,32};
      if (k[0]) return (k[4:1] == 0) ? 8'd254 : 8'(2 * k[4:1]);
      return evens[k[4:1]];
   endfunction

   function automatic logic pat_bit(input logic [1:0] d, input logic [2:0] s);
      logic [7:0] p [4] = '{8'b01000000, 8'b01100000, 8'b01111000, 8'b10011111};
      return p[d][7 - s];
   endfunction

   function automatic logic [11:0] raw_target(input logic [10:0] per, input logic [7:0] r1);
      int unsigned sh = per >> r1[2:0];
      int          v;
      if (!r1[3]) return 12'(per + sh);
      v = int'(per) - int'(sh) - 1;   // default build: ones-complement style
      return (v < 0) ? 12'd0 : 12'(v);
   endfunction

   function automatic logic silent(input logic [10:0] per, input logic [7:0] r1);
      return (per < 8) || raw_target(per, r1) > 12'h7FF;
   endfunction

   function automatic logic [3:0] exp_level();
      logic [3:0] vol = m_r0[4] ? m_r0[3:0] : m_elvl;
      if (pat_bit(m_r0[7:6], m_step) && m_len != 0 && !silent(m_per, m_r1)) return vol;
      return 4'd0;
   endfunction

   wire b_w0 = wr_en && wr_addr == 2'd0;
   wire b_w1 = wr_en && wr_addr == 2'd1;
   wire b_w2 = wr_en && wr_addr == 2'd2;
   wire b_w3 = wr_en && wr_addr == 2'd3;
   wire b_fire = half_pulse && m_sdiv == 3'd0;
   wire b_upd  = b_fire && m_r1[7] && m_r1[2:0] != 0 && !silent(m_per, m_r1);

   always @(posedge clk) begin
      if (!rst_n) begin
         m_r0 <= 0; m_r1 <= 0; m_per <= 0; m_tcnt <= 0; m_tgl <= 0; m_step <= 0;
         m_arm <= 0; m_ediv <= 0; m_elvl <= 0; m_sdiv <= 0; m_rl <= 0; m_len <= 0;
      end else begin
         if (cpu_tick) begin
            if (m_tcnt == 0) begin
               m_tcnt <= m_per; m_tgl <= !m_tgl;
               if (m_tgl) m_step <= m_step + 3'd1;
            end else m_tcnt <= m_tcnt - 11'd1;
         end
         if (b_w3) m_step <= 0;
         if (b_w0) m_r0 <= wr_data;
         if (b_w1) m_r1 <= wr_data;
         if (b_w2) m_per[7:0] <= wr_data;
         if (b_w3) m_per[10:8] <= wr_data[2:0];
         if (!b_w2 && !b_w3 && b_upd) m_per <= raw_target(m_per, m_r1)[10:0];
         if (qtr_pulse) begin
            if (m_arm) begin m_elvl <= 15; m_ediv <= m_r0[3:0]; end
            else if (m_ediv == 0) begin
               m_ediv <= m_r0[3:0];
               if (m_elvl != 0) m_elvl <= m_elvl - 4'd1;
               else if (m_r0[5]) m_elvl <= 15;
            end else m_ediv <= m_ediv - 4'd1;
         end
         m_arm <= b_w3 ? 1'b1 : (qtr_pulse ? 1'b0 : m_arm);
         if (half_pulse) m_sdiv <= (b_fire || m_rl) ? m_r1[6:4] : m_sdiv - 3'd1;
         m_rl <= b_w1 ? 1'b1 : (half_pulse ? 1'b0 : m_rl);
         if (!chan_en) m_len <= 0;
         else if (b_w3) m_len <= tbl(wr_data[7:3]);
         else if (half_pulse && !m_r0[5] && m_len != 0) m_len <= m_len - 8'd1;
      end
   end

   // ---------------- check helpers ----------------
   task automatic expect_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cmp_model(input string req);
      expect_eq({req, " level"}, level_out, exp_level());
      expect_eq({req, " len_active"}, len_active, m_len != 0);
   endtask

   // wait one cycle, drop strobes, compare at the falling edge
   task automatic cyc(input string req);
      @(negedge clk);
      wr_en = 0; qtr_pulse = 0; half_pulse = 0;
      cmp_model(req);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d, input string req);
      wr_en = 1; wr_addr = a; wr_data = d;
      cyc(req);
   endtask

   task automatic half(input string req);
      qtr_pulse = 1; half_pulse = 1;
      cyc(req);
   endtask

   task automatic run(input int n, input string req);
      for (int i = 0; i < n; i++) cyc(req);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      expect_eq("R1 level in reset", level_out, 0);
      expect_eq("R1 len_active in reset", len_active, 0);
      rst_n = 1;
      cyc("R1");
      expect_eq("R1 level after reset", level_out, 0);

      // duration table and halt (R9, R10, R12)
      chan_en = 1; cpu_tick = 1;
      wr(2'd0, 8'h00, "R9");
      wr(2'd3, 8'h18, "R9");                 // index 3 -> 2
      expect_eq("R12 loaded", len_active, 1);
      half("R10");
      expect_eq("R10 one left", len_active, 1);
      half("R10");
      expect_eq("R10 expired after two", len_active, 0);
      wr(2'd0, 8'h20, "R10");                // halt set
      wr(2'd3, 8'h18, "R9");
      half("R10"); half("R10"); half("R10");
      expect_eq("R10 halt holds count", len_active, 1);
      chan_en = 0;
      cyc("R10");
      expect_eq("R10 disable clears", len_active, 0);
      wr(2'd3, 8'h08, "R9");
      expect_eq("R9 write while disabled", len_active, 0);
      chan_en = 1;

      // mute below 8 (R7)
      wr(2'd0, 8'hBF, "R7");
      wr(2'd2, 8'h07, "R7");
      wr(2'd3, 8'h08, "R7");                 // index 1 -> 254, period 7
      for (int i = 0; i < 64; i++) begin
         cyc("R7");
         expect_eq("R7 period below 8 silent", level_out, 0);
      end

      // tone and duty, constant volume (R2, R3, R5, R11)
      wr(2'd2, 8'h03, "R2");
      wr(2'd3, 8'h08, "R2");
      run(300, "R2");
      wr(2'd0, 8'h3F, "R3");                 // duty change mid-cycle, step kept
      run(200, "R3");
      wr(2'd0, 8'hF5, "R5");
      run(200, "R5");

      // envelope decay and loop (R4)
      wr(2'd0, 8'hA0, "R4");                 // duty2, loop, n=0
      wr(2'd3, 8'h08, "R4");
      for (int i = 0; i < 40; i++) begin
         qtr_pulse = 1; cyc("R4"); run(7, "R4");
      end

      // sweep up, down, and overflow mute (R6, R7, R8)
      wr(2'd2, 8'h40, "R8");
      wr(2'd3, 8'h09, "R8");                 // period 0x140
      wr(2'd1, 8'h91, "R8");                 // enable, rate 1, shift 1
      for (int i = 0; i < 12; i++) begin half("R8"); run(20, "R8"); end
      wr(2'd1, 8'h99, "R6");                 // negate
      for (int i = 0; i < 12; i++) begin half("R6"); run(20, "R6"); end
      wr(2'd2, 8'h00, "R7");
      wr(2'd3, 8'h0C, "R7");                 // period 0x400, shift 0 add overflows
      wr(2'd1, 8'h80, "R7");
      half("R7"); run(40, "R7");

      // constrained random traffic against the model (R2..R11)
      for (int i = 0; i < 30000; i++) begin
         cpu_tick = ($urandom % 4) != 0;
         if (($urandom % 24) == 0) begin qtr_pulse = 1; half_pulse = $urandom % 2; end
         if (($urandom % 700) == 0) chan_en = !chan_en;
         if (!chan_en && ($urandom % 40) == 0) chan_en = 1;
         if (($urandom % 12) == 0) begin
            wr_en = 1; wr_addr = 2'($urandom); wr_data = 8'($urandom);
            if (wr_addr == 2'd3 && ($urandom % 2)) wr_data[2:0] = 3'd0;
         end
         cyc("R11");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule